// File: doc/BRIEF.md
# Bus-Mastered Temperature Sampling Sequencer

This block gathers temperature samples from an auxiliary ADC that lives elsewhere on the chip's bus. It has no converter of its own. A timebase starts a measurement round at a fixed period. In each round the block visits every enabled sensing point, lowest index first. For each point it uses single-beat bus writes to steer the analog sensor mux and to select and enable the ADC channel. It then polls a status word until a valid bit shows up, and keeps the 12-bit result in a per-point measurement slot.

All bus addresses, write values, the valid-bit position, its polarity and the result shift come in as configuration inputs. The same block can therefore drive any converter that fits this write-then-poll pattern. The status word and the data word may live at the same address, in which case one read supplies both.

Top module: `therm_seq`

## Requirements
- R1: While reset is held and until the first round begins, `bus_req`, `round_done` and `timeout_flag` are 0 and every measurement slot is 0.
- R2: A round begins every `cfg_round_ivl` × (`cfg_unit` × 256) clock cycles, counted from the previous round start, provided the previous round has already finished.
- R3: A round never begins while another is in progress. When the interval has already run out at completion, the next round's first bus request is raised in the cycle right after the one-cycle `round_done` pulse. `bus_req` is 0 whenever `round_done` is 1.
- R4: Only points whose bit is set in `cfg_pt_en` are visited, in ascending index order. Slots of disabled points keep their value.
- R5: When `cfg_wr_ctl[0]` is 1, each point starts with a write of its 8-bit code, `cfg_mux_codes[8i+7:8i]` zero-extended, to `cfg_sel_addr`. When it is 0, no such write occurs.
- R6: When `cfg_wr_ctl[1]` is 1, `cfg_chan_val` is written to `cfg_chclr_addr`. After that, and in every case, `cfg_chan_val` is written to `cfg_chset_addr`, once per point.
- R7: A read word is valid when its bit `cfg_vld_pos` equals `cfg_vld_hi`. With `cfg_vld_hi`=1 the valid bit is active high, and with 0 it is active low.
- R8: When `cfg_vld_addr` equals `cfg_dat_addr`, the valid read also supplies the result. Otherwise one extra read of `cfg_dat_addr` follows the valid read.
- R9: The stored result is bits `cfg_shift`+11 down to `cfg_shift` of the data word. It goes to `meas[12i+11:12i]` for point i. Slots change only on a completed read.
- R10: Before every valid read of a point there are max(`cfg_poll_ivl`,1) idle cycles, counted after the enable write or after the previous valid read.
- R11: After `cfg_poll_limit` reads without a valid bit (at least one), the point is abandoned. Its slot is kept, `timeout_flag` sets and stays set until reset, and the next point is served. A limit of all ones never abandons.
- R12: A valid word seen on the last allowed poll is stored and does not set `timeout_flag`.
- R13: Only one bus transaction is active at a time. `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold steady until `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_unit | input | 10 | Timebase unit, in steps of 256 cycles |
| cfg_round_ivl | input | 10 | Round interval, in timebase units |
| cfg_pt_en | input | 4 | Sensing point enable mask |
| cfg_wr_ctl | input | 2 | Bit 0 enables the sensor-mux write, bit 1 enables the channel-clear write |
| cfg_mux_codes | input | 32 | Per-point sensor mux codes, 8 bits each |
| cfg_chan_val | input | 32 | ADC channel select and enable value |
| cfg_sel_addr | input | 32 | Sensor mux address |
| cfg_chclr_addr | input | 32 | Channel clear address |
| cfg_chset_addr | input | 32 | Channel set (enable) address |
| cfg_vld_addr | input | 32 | Address polled for the valid bit |
| cfg_dat_addr | input | 32 | Address of the result word |
| cfg_vld_pos | input | 5 | Valid bit position |
| cfg_vld_hi | input | 1 | Valid polarity, 1 for active high |
| cfg_shift | input | 5 | Right shift applied to the result word |
| cfg_poll_ivl | input | 16 | Idle cycles before each valid read |
| cfg_poll_limit | input | 16 | Maximum reads without a valid bit, all ones for none |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Transaction address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, taken when `bus_ready` is 1 |
| bus_ready | input | 1 | Transaction completes in this cycle |
| meas | output | 48 | Four 12-bit measurement slots |
| round_done | output | 1 | One-cycle pulse at the end of each round |
| timeout_flag | output | 1 | Sticky poll-timeout indication |

## Verification
The valid bit can arrive on exactly the read where the poll budget runs out. In that cycle the store path and the abandon path both qualify. The bench sets the poll limit to three and makes the modelled converter turn valid on its third read. It expects every slot refreshed and the timeout flag clear. Then it moves validity to the fifth read and expects the slots untouched and the flag set. A second collision is the interval expiring during a long round. This is provoked with a zero interval and judged by a bus request appearing in the cycle right after the completion pulse.

// File: rtl/therm_seq.sv
module therm_seq #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NPT = 4,
  parameter int MW  = 8,
  parameter int RW  = 12,
  parameter int PW  = 16,
  parameter int TW  = 16,
  parameter int UW  = 10
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UW-1:0]     cfg_unit,
  input  logic [UW-1:0]     cfg_round_ivl,
  input  logic [NPT-1:0]    cfg_pt_en,
  input  logic [1:0]        cfg_wr_ctl,
  input  logic [NPT*MW-1:0] cfg_mux_codes,
  input  logic [DW-1:0]     cfg_chan_val,
  input  logic [AW-1:0]     cfg_sel_addr,
  input  logic [AW-1:0]     cfg_chclr_addr,
  input  logic [AW-1:0]     cfg_chset_addr,
  input  logic [AW-1:0]     cfg_vld_addr,
  input  logic [AW-1:0]     cfg_dat_addr,
  input  logic [$clog2(DW)-1:0] cfg_vld_pos,
  input  logic              cfg_vld_hi,
  input  logic [$clog2(DW)-1:0] cfg_shift,
  input  logic [PW-1:0]     cfg_poll_ivl,
  input  logic [TW-1:0]     cfg_poll_limit,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready,
  output logic [NPT*RW-1:0] meas,
  output logic              round_done,
  output logic              timeout_flag
);
  localparam int IW = (NPT > 1) ? $clog2(NPT) : 1;
  localparam int CW = UW + 8;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_CLR, S_SET, S_WAIT, S_RDV, S_RDD} st_t;

  st_t st, entry_st;
  logic [IW-1:0] cur, first_idx, next_idx;
  logic first_ok, next_ok;
  logic [CW-1:0] unit_cnt;
  logic [UW-1:0] ivl_cnt;
  logic [PW-1:0] wcnt;
  logic [TW-1:0] pcnt;
  logic [NPT*RW-1:0] meas_q;
  logic done_q, tmo_q;

  wire unit_wrap = ({1'b0, unit_cnt} + 1'b1) >= {1'b0, cfg_unit, 8'd0};
  wire due = (ivl_cnt >= cfg_round_ivl) ||
             (unit_wrap && (({1'b0, ivl_cnt} + 1'b1) >= {1'b0, cfg_round_ivl}));
  wire start = (st == S_IDLE) && due;

  wire xfer      = bus_req && bus_ready;
  wire vld_hit   = (bus_rdata[cfg_vld_pos] == cfg_vld_hi);
  wire same_addr = (cfg_vld_addr == cfg_dat_addr);
  wire [RW-1:0] sample = RW'(bus_rdata >> cfg_shift);
  wire [PW:0] wnext = {1'b0, wcnt} + 1'b1;
  wire [TW:0] pnext = {1'b0, pcnt} + 1'b1;
  wire give_up = (~&cfg_poll_limit) && (pnext >= {1'b0, cfg_poll_limit});
  wire rd_ok   = xfer && (st == S_RDV) && vld_hit;
  wire rd_miss = xfer && (st == S_RDV) && !vld_hit;
  wire store   = (rd_ok && same_addr) || (xfer && st == S_RDD);
  wire adv     = store || (rd_miss && give_up);

  always_comb begin
    first_ok = 1'b0;
    next_ok = 1'b0;
    first_idx = '0;
    next_idx = '0;
    for (int k = NPT - 1; k >= 0; k--) begin
      if (cfg_pt_en[k]) begin
        first_ok = 1'b1;
        first_idx = IW'(k);
      end
      if (cfg_pt_en[k] && k > int'(cur)) begin
        next_ok = 1'b1;
        next_idx = IW'(k);
      end
    end
  end

  always_comb begin
    if (cfg_wr_ctl[0])      entry_st = S_SEL;
    else if (cfg_wr_ctl[1]) entry_st = S_CLR;
    else                    entry_st = S_SET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0;
      unit_cnt <= '0;
      ivl_cnt <= '0;
      wcnt <= '0;
      pcnt <= '0;
      meas_q <= '0;
      done_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        unit_cnt <= '0;
        ivl_cnt <= '0;
      end else begin
        unit_cnt <= unit_wrap ? '0 : unit_cnt + 1'b1;
        if (unit_wrap && ivl_cnt < cfg_round_ivl) ivl_cnt <= ivl_cnt + 1'b1;
      end
      if (store) meas_q[int'(cur)*RW +: RW] <= sample;
      if (rd_miss && give_up) tmo_q <= 1'b1;
      if (adv) begin
        if (next_ok) begin
          cur <= next_idx;
          st <= entry_st;
        end else begin
          st <= S_IDLE;
          done_q <= 1'b1;
        end
      end else begin
        case (st)
          S_IDLE: if (start) begin
            if (first_ok) begin
              cur <= first_idx;
              st <= entry_st;
            end else done_q <= 1'b1;
          end
          S_SEL: if (xfer) st <= cfg_wr_ctl[1] ? S_CLR : S_SET;
          S_CLR: if (xfer) st <= S_SET;
          S_SET: if (xfer) begin
            st <= S_WAIT;
            wcnt <= '0;
            pcnt <= '0;
          end
          S_WAIT: begin
            wcnt <= wcnt + 1'b1;
            if (wnext >= {1'b0, cfg_poll_ivl}) st <= S_RDV;
          end
          S_RDV: if (xfer) begin
            if (vld_hit) st <= S_RDD;
            else begin
              pcnt <= pcnt + 1'b1;
              wcnt <= '0;
              st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign bus_req = (st == S_SEL) || (st == S_CLR) || (st == S_SET) ||
                   (st == S_RDV) || (st == S_RDD);
  assign bus_we  = (st == S_SEL) || (st == S_CLR) || (st == S_SET);

  always_comb begin
    bus_addr = '0;
    bus_wdata = '0;
    case (st)
      S_SEL: begin
        bus_addr = cfg_sel_addr;
        bus_wdata = DW'(cfg_mux_codes[int'(cur)*MW +: MW]);
      end
      S_CLR: begin
        bus_addr = cfg_chclr_addr;
        bus_wdata = cfg_chan_val;
      end
      S_SET: begin
        bus_addr = cfg_chset_addr;
        bus_wdata = cfg_chan_val;
      end
      S_RDV: bus_addr = cfg_vld_addr;
      S_RDD: bus_addr = cfg_dat_addr;
      default: ;
    endcase
  end

  assign meas = meas_q;
  assign round_done = done_q;
  assign timeout_flag = tmo_q;
endmodule

// File: rtl/therm_seq_chk.sv
module therm_seq_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NPT = 4,
  parameter int RW  = 12
)(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_ready,
  input logic [NPT*RW-1:0] meas,
  input logic              round_done,
  input logic              timeout_flag
);
  a_r13_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  a_r11_flag_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(bus_req && bus_ready && !bus_we));

  a_r3_done_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |-> !bus_req);

  a_r9_meas_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_ready && !bus_we) |=> $stable(meas));
endmodule

bind therm_seq therm_seq_chk #(.AW(AW), .DW(DW), .NPT(NPT), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ready(bus_ready), .meas(meas), .round_done(round_done),
  .timeout_flag(timeout_flag)
);

// File: tb/therm_seq_tb_top.sv
module therm_seq_tb_top;
  localparam logic [31:0] A_SEL = 32'h1000_0604;
  localparam logic [31:0] A_CLR = 32'h2000_000C;
  localparam logic [31:0] A_SET = 32'h2000_0008;
  localparam logic [31:0] A_DAT = 32'h2000_0040;
  localparam logic [31:0] A_VLD = 32'h2000_0044;
  localparam logic [31:0] CODES = {8'd16, 8'd3, 8'd2, 8'd0};
  // {mask, vpos, vhi, shift, same, lat, stall, off}
  localparam logic [33:0] VEC [6] = '{
    {4'b1111, 5'd12, 1'b1, 5'd0,  1'b1, 4'd1, 2'd0, 12'h100},
    {4'b0011, 5'd20, 1'b1, 5'd4,  1'b0, 4'd2, 2'd1, 12'h200},
    {4'b0101, 5'd3,  1'b0, 5'd8,  1'b1, 4'd3, 2'd0, 12'h300},
    {4'b1010, 5'd0,  1'b1, 5'd16, 1'b0, 4'd1, 2'd2, 12'h050},
    {4'b1000, 5'd30, 1'b0, 5'd2,  1'b1, 4'd2, 2'd1, 12'h7A0},
    {4'b0001, 5'd14, 1'b1, 5'd0,  1'b0, 4'd4, 2'd0, 12'hABC}
  };

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [9:0] cfg_unit = 10'd1, cfg_round_ivl = 10'd1;
  logic [3:0] cfg_pt_en = 4'hF;
  logic [1:0] cfg_wr_ctl = 2'b11;
  logic [4:0] vpos = 5'd12, sh = 5'd0;
  logic vhi = 1'b1, same = 1'b1;
  logic [15:0] cfg_poll_ivl = 16'd1, cfg_poll_limit = 16'hFFFF;
  int lat = 1, stall = 0;
  logic [11:0] off = 12'h000;

  logic bus_req, bus_we, round_done, timeout_flag;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ready = 1'b0;
  logic [47:0] meas;
  wire [31:0] vld_addr = same ? A_DAT : A_VLD;

  therm_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_unit(cfg_unit), .cfg_round_ivl(cfg_round_ivl),
    .cfg_pt_en(cfg_pt_en), .cfg_wr_ctl(cfg_wr_ctl), .cfg_mux_codes(CODES),
    .cfg_chan_val(32'h0000_0800), .cfg_sel_addr(A_SEL), .cfg_chclr_addr(A_CLR),
    .cfg_chset_addr(A_SET), .cfg_vld_addr(vld_addr), .cfg_dat_addr(A_DAT),
    .cfg_vld_pos(vpos), .cfg_vld_hi(vhi), .cfg_shift(sh), .cfg_poll_ivl(cfg_poll_ivl),
    .cfg_poll_limit(cfg_poll_limit), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .meas(meas), .round_done(round_done), .timeout_flag(timeout_flag)
  );

  int sel_n = 0, clr_n = 0, set_n = 0, vr_n = 0, dr_n = 0, rd_since = 0, scnt = 0;
  logic [7:0] sel_log [64];
  int vr_t [64];
  logic [7:0] last_code = 8'd0;

  function automatic logic [11:0] volt(input logic [7:0] code);
    return 12'(int'(code) * 37 + int'(off));
  endfunction

  function automatic logic [31:0] mkword(input logic ok, input logic with_vld, input logic with_dat);
    logic [31:0] w;
    w = 32'h8000_0000;
    if (with_dat) w = w | (32'(volt(last_code)) << sh);
    if (with_vld) w[vpos] = vhi ? ok : !ok;
    return w;
  endfunction

  always @(negedge clk) begin
    if (bus_req) begin
      if (scnt >= stall) begin
        bus_ready <= 1'b1;
        scnt <= 0;
        if (bus_we) begin
          bus_rdata <= '0;
          if (bus_addr == A_SEL) begin
            sel_log[sel_n[5:0]] <= bus_wdata[7:0];
            sel_n <= sel_n + 1;
            last_code <= bus_wdata[7:0];
          end
          if (bus_addr == A_CLR) clr_n <= clr_n + 1;
          if (bus_addr == A_SET) begin
            set_n <= set_n + 1;
            rd_since <= 0;
          end
        end else if (bus_addr == vld_addr) begin
          rd_since <= rd_since + 1;
          vr_t[vr_n[5:0]] <= cyc;
          vr_n <= vr_n + 1;
          bus_rdata <= mkword(rd_since + 1 >= lat, 1'b1, same);
        end else begin
          dr_n <= dr_n + 1;
          bus_rdata <= mkword(1'b0, 1'b0, 1'b1);
        end
      end else begin
        bus_ready <= 1'b0;
        scnt <= scnt + 1;
      end
    end else begin
      bus_ready <= 1'b0;
      scnt <= 0;
    end
  end

  int checks = 0, fails = 0;
  int b_sel, b_clr, b_set, b_vr, b_dr;
  logic [11:0] em [4];

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!round_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!round_done) chk("R3", "round completion", 0, 1);
  endtask

  task automatic snap();
    b_sel = sel_n; b_clr = clr_n; b_set = set_n; b_vr = vr_n; b_dr = dr_n;
  endtask

  task automatic check_meas(input logic [3:0] mask, input string rq);
    for (int i = 0; i < 4; i++) begin
      if (mask[i]) em[i] = volt(CODES[8*i +: 8]);
      chk(mask[i] ? rq : "R4", $sformatf("slot %0d", i), meas[12*i +: 12], em[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "req in reset", bus_req, 0);
    chk("R1", "meas in reset", meas, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "req after reset", bus_req, 0);
    chk("R1", "done after reset", round_done, 0);
    chk("R1", "flag after reset", timeout_flag, 0);
    chk("R1", "meas after reset", meas, 0);
    wait_done();
    for (int i = 0; i < 4; i++) em[i] = volt(CODES[8*i +: 8]);

    for (int v = 0; v < 6; v++) begin
      int n, j;
      {cfg_pt_en, vpos, vhi, sh, same} = VEC[v][33:18];
      lat = int'(VEC[v][17:14]);
      stall = int'(VEC[v][13:12]);
      off = VEC[v][11:0];
      snap();
      wait_done();
      check_meas(cfg_pt_en, "R9");
      n = $countones(cfg_pt_en);
      chk("R5", "mux writes", sel_n - b_sel, n);
      j = 0;
      for (int i = 0; i < 4; i++)
        if (cfg_pt_en[i]) begin
          chk("R4", "visit order", sel_log[6'(b_sel + j)], CODES[8*i +: 8]);
          j++;
        end
      chk("R6", "clear writes", clr_n - b_clr, n);
      chk("R6", "enable writes", set_n - b_set, n);
      chk("R8", "data reads", dr_n - b_dr, same ? 0 : n);
      chk("R7", "polls until valid", vr_n - b_vr, n * lat);
    end
    chk("R11", "no flag with unlimited polls", timeout_flag, 0);

    cfg_pt_en = 4'hF; vpos = 5'd12; vhi = 1'b1; sh = 5'd0; same = 1'b1; lat = 1; stall = 0;
    cfg_wr_ctl = 2'b00;
    snap();
    wait_done();
    chk("R5", "no mux writes", sel_n - b_sel, 0);
    chk("R6", "no clear writes", clr_n - b_clr, 0);
    chk("R6", "enable writes only", set_n - b_set, 4);
    cfg_wr_ctl = 2'b01;
    snap();
    wait_done();
    chk("R5", "mux writes restored", sel_n - b_sel, 4);
    chk("R6", "clear skipped", clr_n - b_clr, 0);
    cfg_wr_ctl = 2'b11;

    cfg_pt_en = 4'b0001; cfg_poll_ivl = 16'd5; lat = 3;
    snap();
    wait_done();
    chk("R10", "poll count", vr_n - b_vr, 3);
    chk("R10", "poll gap 1", vr_t[6'(b_vr + 1)] - vr_t[6'(b_vr)], 6);
    chk("R10", "poll gap 2", vr_t[6'(b_vr + 2)] - vr_t[6'(b_vr + 1)], 6);

    cfg_pt_en = 4'hF; cfg_poll_ivl = 16'd1; lat = 1; cfg_unit = 10'd2;
    begin
      int t1;
      wait_done();
      wait_done();
      t1 = cyc;
      wait_done();
      chk("R2", "round period", cyc - t1, 512);
    end
    cfg_unit = 10'd1; cfg_round_ivl = 10'd0;
    wait_done();
    wait_done();
    @(negedge clk);
    chk("R3", "restart right after done", bus_req, 1);
    wait_done();
    cfg_round_ivl = 10'd1;

    lat = 12; off = 12'h555;
    wait_done();
    check_meas(4'hF, "R11");
    chk("R11", "all-ones limit never gives up", timeout_flag, 0);

    lat = 3; cfg_poll_limit = 16'd3; off = 12'h666;
    wait_done();
    check_meas(4'hF, "R12");
    chk("R12", "valid on last poll no flag", timeout_flag, 0);

    lat = 5; off = 12'h777;
    snap();
    wait_done();
    check_meas(4'h0, "R11");
    chk("R11", "flag on timeout", timeout_flag, 1);
    chk("R11", "polls before abandon", vr_n - b_vr, 12);

    lat = 1; off = 12'h111;
    wait_done();
    check_meas(4'hF, "R9");
    chk("R11", "flag sticky", timeout_flag, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule